// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes commands for a behavioural NOR-style flash memory. The host writes single-byte commands on a parallel bus. A write counts only while chip enable and write enable are both low. The controller decides whether reads return array data, status or nothing. It runs a two-write setup/confirm handshake before it starts a program or an erase. While an operation runs, it holds a ready/busy line low.

The program and erase engine is modelled as a countdown timer. The array itself sits outside the block. The block tells the array to program or erase through one-cycle strobes, and passes array read data through when in array mode. A digital write-lockout flag stands in for supply lockout.

An active-low power-down input aborts an operation in progress and clears the status. The block then rests in a quiet state until that input returns high. After power-on or power-down it always comes back in array-read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After power-on reset the block is in array mode: `dOut` equals `arrRdData`, `rdyBsy` is 1 and no array strobe is active.
- R2: A command is taken once, on the first clock edge at which `ceN` and `weN` are both low. Holding both low for several cycles gives one command. A write with either enable high has no effect.
- R3: Command 0x70 selects status mode, in which `dOut` shows the status byte. Command 0xFF selects array mode.
- R4: Command 0x40 followed by any data write pulses `arrWrEn` for one cycle, with `arrWrData` equal to that data. `rdyBsy` and status bit 7 are then 0 for exactly PROG_CYCLES cycles.
- R5: Command 0x20 followed by 0xD0 pulses `arrErase` for one cycle. `rdyBsy` is then 0 for exactly ERASE_CYCLES cycles.
- R6: After 0x20, a second write other than 0xD0 starts nothing. It sets status bits 5 and 4 (sequence error), so the status reads 0xB0.
- R7: While `lockout` is 1, program and erase give no array strobe. A locked program sets status bits 4 and 3 (0x98). A locked erase sets status bits 5 and 3 (0xA8).
- R8: After a program or erase completes, reads keep returning status until a 0xFF command.
- R9: Command 0x50 clears status bits 5, 4 and 3 and leaves the read mode unchanged.
- R10: If `pdN` goes low during an operation, `rdyBsy` stays low for ABORT_CYCLES more cycles and the block then enters power-down. In power-down `dOut` is 0, `rdyBsy` is 1 and writes are ignored. If `pdN` goes low when no operation is running, power-down starts on the next edge.
- R11: Power-down clears every status error bit and sets no completion status. When `pdN` returns high, the block is in array mode and the status reads 0x80.
- R12: Writes that arrive while the engine is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| pdN | input | 1 | Active-low reset/power-down request |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| din | input | DATA_W | Command/data write bus |
| lockout | input | 1 | Supply-lockout flag; blocks program and erase |
| arrRdData | input | DATA_W | Read data from the array |
| dOut | output | DATA_W | Read data: array, status or 0 |
| rdyBsy | output | 1 | 1 when ready, 0 while busy or aborting |
| arrWrEn | output | 1 | One-cycle program strobe to the array |
| arrErase | output | 1 | One-cycle erase strobe to the array |
| arrWrData | output | DATA_W | Data captured for the program strobe |

## Verification
A wrong decoder state shows on `dOut` on the very next read. Examples are a setup state left behind, a lost status-mode flag, or a command repeated while the enables stay low. The symptom is array data where status was expected, or a sequence-error byte where 0x80 was expected. It can also show as an array strobe that the scoreboard did not predict, at the negedge just after the offending edge. Timer faults show as a busy window that is one or more cycles off from PROG_CYCLES, ERASE_CYCLES or ABORT_CYCLES. A fault in the error bits shows only at the next status read, so every sequence ends with one.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_PROG_SET  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SET = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

  localparam int STB_READY = 7;
  localparam int STB_ERASE = 5;
  localparam int STB_PROG  = 4;
  localparam int STB_LOCK  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PSET, ST_ESET, ST_BUSY, ST_ABORT, ST_PDOWN
  } ctlState_t;

  typedef enum logic [1:0] {
    TMR_PROG, TMR_ERASE, TMR_ABORT
  } tmrSel_t;

  typedef struct packed {
    logic       tmrLoad;
    tmrSel_t    tmrSel;
    logic       progGo;
    logic       eraseGo;
    logic       clrErr;
    logic       clrAll;
    logic [6:0] setErr;
  } dpStrobe_t;

endpackage

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              pdN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [DATA_W-1:0] din,
  input  logic              lockout,
  input  logic              tmrDone,
  output dpStrobe_t         strb,
  output logic              statusMode,
  output logic              engBusy,
  output logic              pwrDown
);

  ctlState_t state, nextState;
  logic      nextMode;
  logic      wrEn, wrEnQ, wrStrobe;
  logic [7:0] cmd;

  assign wrEn     = !ceN && !weN;
  assign wrStrobe = wrEn && !wrEnQ;
  assign cmd      = din[7:0];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state      <= ST_IDLE;
      statusMode <= 1'b0;
      wrEnQ      <= 1'b0;
    end else begin
      state      <= nextState;
      statusMode <= nextMode;
      wrEnQ      <= wrEn;
    end
  end

  always_comb begin
    nextState = state;
    nextMode  = statusMode;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (!pdN) begin
          nextState   = ST_PDOWN;
          nextMode    = 1'b0;
          strb.clrAll = 1'b1;
        end else if (wrStrobe) begin
          unique case (cmd)
            CMD_RD_ARRAY:  nextMode = 1'b0;
            CMD_RD_STATUS: nextMode = 1'b1;
            CMD_CLR_STAT:  strb.clrErr = 1'b1;
            CMD_PROG_SET: begin
              nextState = ST_PSET;
              nextMode  = 1'b1;
            end
            CMD_ERASE_SET: begin
              nextState = ST_ESET;
              nextMode  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_PSET: begin
        if (!pdN) begin
          nextState   = ST_PDOWN;
          nextMode    = 1'b0;
          strb.clrAll = 1'b1;
        end else if (wrStrobe) begin
          if (lockout) begin
            nextState = ST_IDLE;
            strb.setErr[STB_PROG] = 1'b1;
            strb.setErr[STB_LOCK] = 1'b1;
          end else begin
            nextState    = ST_BUSY;
            strb.progGo  = 1'b1;
            strb.tmrLoad = 1'b1;
            strb.tmrSel  = TMR_PROG;
          end
        end
      end
      ST_ESET: begin
        if (!pdN) begin
          nextState   = ST_PDOWN;
          nextMode    = 1'b0;
          strb.clrAll = 1'b1;
        end else if (wrStrobe) begin
          if (cmd != CMD_CONFIRM) begin
            nextState = ST_IDLE;
            strb.setErr[STB_ERASE] = 1'b1;
            strb.setErr[STB_PROG]  = 1'b1;
          end else if (lockout) begin
            nextState = ST_IDLE;
            strb.setErr[STB_ERASE] = 1'b1;
            strb.setErr[STB_LOCK]  = 1'b1;
          end else begin
            nextState    = ST_BUSY;
            strb.eraseGo = 1'b1;
            strb.tmrLoad = 1'b1;
            strb.tmrSel  = TMR_ERASE;
          end
        end
      end
      ST_BUSY: begin
        if (!pdN) begin
          nextState    = ST_ABORT;
          strb.tmrLoad = 1'b1;
          strb.tmrSel  = TMR_ABORT;
          strb.clrAll  = 1'b1;
        end else if (tmrDone) begin
          nextState = ST_IDLE;
        end
      end
      ST_ABORT: begin
        strb.clrAll = 1'b1;
        if (tmrDone) begin
          nextState = ST_PDOWN;
          nextMode  = 1'b0;
        end
      end
      ST_PDOWN: begin
        strb.clrAll = 1'b1;
        nextMode    = 1'b0;
        if (pdN) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign engBusy = (state == ST_BUSY) || (state == ST_ABORT);
  assign pwrDown = (state == ST_PDOWN);

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int ABORT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  dpStrobe_t         strb,
  input  logic              engBusy,
  input  logic              pwrDown,
  input  logic              statusMode,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] arrRdData,
  output logic              tmrDone,
  output logic              arrWrEn,
  output logic              arrErase,
  output logic [DATA_W-1:0] arrWrData,
  output logic [DATA_W-1:0] dOut
);

  localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_CYC = (MAX_A > ABORT_CYCLES) ? MAX_A : ABORT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] tmrCnt, tmrLen;
  logic [6:0]       errBits;
  logic [7:0]       statusByte;

  always_comb begin
    unique case (strb.tmrSel)
      TMR_PROG:  tmrLen = CNT_W'(PROG_CYCLES - 1);
      TMR_ERASE: tmrLen = CNT_W'(ERASE_CYCLES - 1);
      default:   tmrLen = CNT_W'(ABORT_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      tmrCnt <= '0;
    end else if (strb.tmrLoad) begin
      tmrCnt <= tmrLen;
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign tmrDone = (tmrCnt == '0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      errBits <= '0;
    end else if (strb.clrAll) begin
      errBits <= '0;
    end else if (strb.clrErr) begin
      errBits[STB_ERASE] <= 1'b0;
      errBits[STB_PROG]  <= 1'b0;
      errBits[STB_LOCK]  <= 1'b0;
    end else begin
      errBits <= errBits | strb.setErr;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      arrWrEn   <= 1'b0;
      arrErase  <= 1'b0;
      arrWrData <= '0;
    end else begin
      arrWrEn  <= strb.progGo;
      arrErase <= strb.eraseGo;
      if (strb.progGo) arrWrData <= din;
    end
  end

  assign statusByte = {!engBusy, errBits};

  always_comb begin
    if (pwrDown)         dOut = '0;
    else if (statusMode) dOut = DATA_W'(statusByte);
    else                 dOut = arrRdData;
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 20,
  parameter int ABORT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              pdN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [DATA_W-1:0] din,
  input  logic              lockout,
  input  logic [DATA_W-1:0] arrRdData,
  output logic [DATA_W-1:0] dOut,
  output logic              rdyBsy,
  output logic              arrWrEn,
  output logic              arrErase,
  output logic [DATA_W-1:0] arrWrData
);

  dpStrobe_t strb;
  logic      statusMode, engBusy, pwrDown, tmrDone;

  flash_cmd_ctl #(.DATA_W(DATA_W)) ctl_i (
    .clk(clk), .porN(porN), .pdN(pdN), .ceN(ceN), .weN(weN), .din(din),
    .lockout(lockout), .tmrDone(tmrDone), .strb(strb),
    .statusMode(statusMode), .engBusy(engBusy), .pwrDown(pwrDown)
  );

  flash_cmd_dp #(
    .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .ABORT_CYCLES(ABORT_CYCLES)
  ) dp_i (
    .clk(clk), .porN(porN), .strb(strb), .engBusy(engBusy),
    .pwrDown(pwrDown), .statusMode(statusMode), .din(din),
    .arrRdData(arrRdData), .tmrDone(tmrDone), .arrWrEn(arrWrEn),
    .arrErase(arrErase), .arrWrData(arrWrData), .dOut(dOut)
  );

  assign rdyBsy = !engBusy;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              porN,
  input logic              pdN,
  input logic              ceN,
  input logic              weN,
  input logic              lockout,
  input logic [DATA_W-1:0] dOut,
  input logic              rdyBsy,
  input logic              arrWrEn,
  input logic              arrErase
);

  // R7
  lockout_nostrobe_chk: assert property (@(posedge clk) disable iff (!porN)
    (arrWrEn || arrErase) |-> !$past(lockout));

  // R4
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!porN)
    arrWrEn |=> !arrWrEn);

  // R5
  erase_busy_chk: assert property (@(posedge clk) disable iff (!porN)
    arrErase |-> !rdyBsy);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(rdyBsy) |-> ($past(!ceN && !weN) && (arrWrEn || arrErase)));

  // R10
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (!porN)
    ($past(porN) && $past(!pdN) && $past(rdyBsy)) |-> (dOut == '0 && rdyBsy));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .porN(porN), .pdN(pdN), .ceN(ceN), .weN(weN),
  .lockout(lockout), .dOut(dOut), .rdyBsy(rdyBsy),
  .arrWrEn(arrWrEn), .arrErase(arrErase)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

  localparam int DW    = 8;
  localparam int PROGC = 8;
  localparam int ERASC = 20;
  localparam int ABRTC = 4;
  localparam logic [7:0] ARR = 8'h5A;

  logic clk = 1'b0;
  logic porN, pdN, ceN, weN, lockout;
  logic [DW-1:0] din, arrRdData, dOut, arrWrData;
  logic rdyBsy, arrWrEn, arrErase;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.DATA_W(DW), .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERASC),
                   .ABORT_CYCLES(ABRTC)) dut_i (
    .clk(clk), .porN(porN), .pdN(pdN), .ceN(ceN), .weN(weN), .din(din),
    .lockout(lockout), .arrRdData(arrRdData), .dOut(dOut), .rdyBsy(rdyBsy),
    .arrWrEn(arrWrEn), .arrErase(arrErase), .arrWrData(arrWrData)
  );

  typedef struct {
    bit         isErase;
    logic [7:0] data;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string curTag = "R1";

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expectStrobe(bit isErase, logic [7:0] data, string tag);
    expItem_t it;
    it.isErase = isErase;
    it.data    = data;
    it.tag     = tag;
    expQ.push_back(it);
  endtask

  task automatic wrHold(logic [7:0] v, int n);
    @(negedge clk);
    din = v; ceN = 1'b0; weN = 1'b0;
    repeat (n) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic wr(logic [7:0] v);
    wrHold(v, 1);
  endtask

  task automatic busyCount(output int n);
    n = 0;
    while (!rdyBsy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // monitor: pops the scoreboard whenever the array sees a strobe
  always @(negedge clk) begin
    if (porN && (arrWrEn || arrErase)) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL %s act=strobe wr=%0b er=%0b exp=none", curTag, arrWrEn, arrErase);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, {31'd0, arrErase}, {31'd0, it.isErase});
        if (!it.isErase) check(it.tag, arrWrData, it.data);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    porN = 1'b0; pdN = 1'b1; ceN = 1'b1; weN = 1'b1; lockout = 1'b0;
    din = '0; arrRdData = ARR;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", dOut, ARR);
    check("R1", rdyBsy, 1);
    check("R1", {arrWrEn, arrErase}, 0);

    // R2 write with chip enable high is blocked
    curTag = "R2";
    @(negedge clk); ceN = 1'b1; weN = 1'b0; din = 8'h70;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    check("R2", dOut, ARR);

    // R3 mode commands
    wr(8'h70);
    check("R3", dOut, 8'h80);
    wr(8'hFF);
    check("R3", dOut, ARR);

    // R4 program
    curTag = "R4";
    expectStrobe(0, 8'hA5, "R4");
    wr(8'h40);
    wr(8'hA5);
    check("R4", dOut, 8'h00);
    busyCount(n);
    check("R4", n, PROGC);
    // R8 stays in status mode
    check("R8", dOut, 8'h80);
    wr(8'hFF);
    check("R8", dOut, ARR);

    // R12 writes while busy ignored
    curTag = "R12";
    expectStrobe(0, 8'h3C, "R12");
    wr(8'h40);
    wr(8'h3C);
    wr(8'hFF);
    wr(8'h40);
    busyCount(n);
    check("R12", dOut, 8'h80);

    // R5 erase, setup held low several cycles (R2: one command)
    curTag = "R5";
    expectStrobe(1, 8'h00, "R5");
    wrHold(8'h20, 5);
    wr(8'hD0);
    busyCount(n);
    check("R5", n, ERASC);
    check("R2", dOut, 8'h80);

    // R6 bad confirm
    curTag = "R6";
    wr(8'h20);
    wr(8'h55);
    @(negedge clk);
    check("R6", dOut, 8'hB0);
    check("R6", rdyBsy, 1);

    // R9 clear status keeps status mode
    wr(8'h50);
    @(negedge clk);
    check("R9", dOut, 8'h80);

    // R7 lockout
    curTag = "R7";
    lockout = 1'b1;
    wr(8'h40);
    wr(8'h11);
    @(negedge clk);
    check("R7", dOut, 8'h98);
    wr(8'h50);
    wr(8'h20);
    wr(8'hD0);
    @(negedge clk);
    check("R7", dOut, 8'hA8);
    check("R7", rdyBsy, 1);
    lockout = 1'b0;

    // R10 abort during program
    curTag = "R10";
    expectStrobe(0, 8'h77, "R10");
    wr(8'h40);
    wr(8'h77);
    repeat (3) @(negedge clk);
    pdN = 1'b0;
    @(negedge clk);
    busyCount(n);
    check("R10", n, ABRTC);
    check("R10", dOut, 8'h00);
    check("R10", rdyBsy, 1);
    wr(8'h40);
    wr(8'h22);
    wr(8'h70);
    @(negedge clk);
    check("R10", dOut, 8'h00);
    // R11 exit: array mode, status cleared
    pdN = 1'b1;
    @(negedge clk);
    check("R11", dOut, ARR);
    wr(8'h70);
    check("R11", dOut, 8'h80);

    // R10 power-down from idle
    @(negedge clk); pdN = 1'b0;
    @(negedge clk);
    check("R10", dOut, 8'h00);
    check("R10", rdyBsy, 1);
    pdN = 1'b1;
    @(negedge clk);
    check("R11", dOut, ARR);

    repeat (3) @(negedge clk);
    check("R4", expQ.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule